// File: doc/BRIEF.md
# Embedded-Clock Pixel Frame Serializer

This block turns one parallel pixel word into one fixed 28-slot serial frame. Each word is 24 data bits and 3 video control bits. Every frame starts with a high-then-low clock-marker pair, so a receiver can find frame edges in any data pattern without training sequences. The 24 data bits are first XORed with a mask taken from a free-running LFSR, and the result is then DC-balanced against a running disparity. An inversion flag and one rotating control bit fill the last two payload slots.

The block runs on a single clock. A one-cycle `bit_en` pulse moves the serial output forward by one slot. A new input word is taken only at the `bit_en` that starts a frame. `frame_start` is high for the whole time the first marker bit is on `ser_bit`. The block uses the 3-bit control field one bit per frame in a fixed rotation, which suits slow video control signals.

Top module: `pixframe_ser`

## Requirements
- R1: A frame is 28 slots long. `frame_start` is 1 while slot 0 is on `ser_bit` and 0 for the other 27 slots. Each `bit_en` advances exactly one slot, and frames follow each other without a gap.
- R2: Slot 0 is always 1 and slot 1 is always 0.
- R3: Slots 2..25 carry the 24 transmitted data bits, bit 0 first. The transmitted word is the input data XOR the scrambler mask, inverted as a whole when slot 26 is 1.
- R4: The scrambler is a 16-bit LFSR with polynomial x^16+x^5+x^4+x^3+1. It shifts left, and its feedback bit is the XOR of state bits 15, 4, 3 and 2. Reset loads the seed 0xACE1, and the LFSR advances once per frame. The mask bit i is state bit (i mod 16), so the mask is {state[7:0], state}.
- R5: Word disparity is 2*(number of ones in the scrambled word) - 24. The word is inverted, and slot 26 set to 1, only when the running disparity and the word disparity are both nonzero and have the same sign.
- R6: The running disparity starts at 0 after reset. The disparity of each word as sent is added to it, and the sum is clamped to the range -64..+64. Because of this, the first frame after reset always has slot 26 = 0.
- R7: Slot 27 carries control bit k of the word taken for that frame. k is 0 for the first frame after reset and then follows the order 0, 1, 2, 0, ...
- R8: Data, control and valid inputs are sampled only at the `bit_en` that starts a frame. Changes at other times do not affect the frame being sent.
- R9: If `pix_valid` is 0 when a frame starts, the data bits are treated as all zero before scrambling. The control bits are still used.
- R10: While `bit_en` is 0, `ser_bit` and `frame_start` hold their values.
- R11: While `rst_n` is low, `ser_bit` and `frame_start` are 0. Reset also restores the seed, a running disparity of 0 and control index 0. The first `bit_en` after release starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| bit_en | input | 1 | Serial-rate enable; one slot per high cycle |
| pix_data | input | 24 | Pixel data word |
| pix_ctrl | input | 3 | Video control bits |
| pix_valid | input | 1 | Data word is valid; when low, zero data is framed |
| ser_bit | output | 1 | Current serial slot value |
| frame_start | output | 1 | High while slot 0 of a frame is on `ser_bit` |

## Verification
The output for a slot is registered at the same rising edge that samples `bit_en` high. The bench therefore drives `bit_en` and the inputs on a falling edge and reads `ser_bit` and `frame_start` on the next falling edge, one cycle later. Input words are latched on the slot-0 edge, so the bench changes inputs right after sampling slot 0 to show they are ignored. After `rst_n` rises, the internal reset clears two edges later, and the bench waits four cycles before the first `bit_en`. A reference model in the bench computes each expected frame from the requirements. During gaps in `bit_en` the bench checks every idle cycle for held outputs.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  localparam int unsigned MARKER_SLOTS = 2;
  localparam int unsigned EXTRA_SLOTS  = 2;
  localparam logic        MARK_HI      = 1'b1;
  localparam logic        MARK_LO      = 1'b0;

  typedef logic signed [15:0] disp_t;
endpackage

// File: rtl/pfs_scrambler.sv
module pfs_scrambler #(
  parameter int unsigned       DATA_W = 24,
  parameter int unsigned       LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS   = 16'h801C,
  parameter logic [LFSR_W-1:0] SEED   = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  output logic [DATA_W-1:0] mask
);
  logic [LFSR_W-1:0] state_q, state_d;
  logic              feedback;

  always_comb begin
    feedback = ^(state_q & TAPS);
    state_d  = state_q;
    if (advance) begin
      state_d = {state_q[LFSR_W-2:0], feedback};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = state_q[i % LFSR_W];
  end

  p_lfsr_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  p_lfsr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(state_q));
endmodule

// File: rtl/pfs_dc_balancer.sv
module pfs_dc_balancer
  import pfs_pkg::*;
#(
  parameter int unsigned DATA_W   = 24,
  parameter int unsigned RD_LIMIT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] word_out,
  output logic              inverted
);
  localparam int unsigned CW  = $clog2(DATA_W + 1);
  localparam disp_t       LIM = disp_t'(RD_LIMIT);

  logic [CW-1:0] ones;
  disp_t         rd_q, rd_d, word_disp, sent_disp, sum;

  always_comb begin
    ones = '0;
    for (int i = 0; i < DATA_W; i++) begin
      ones = ones + CW'(word_in[i]);
    end
    word_disp = (disp_t'(ones) <<< 1) - disp_t'(DATA_W);
    inverted  = ((rd_q > 0) && (word_disp > 0)) ||
                ((rd_q < 0) && (word_disp < 0));
    word_out  = inverted ? ~word_in : word_in;
    sent_disp = inverted ? -word_disp : word_disp;
    sum       = rd_q + sent_disp;
    rd_d      = rd_q;
    if (commit) begin
      if (sum > LIM)       rd_d = LIM;
      else if (sum < -LIM) rd_d = -LIM;
      else                 rd_d = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  p_rd_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q <= LIM) && (rd_q >= -LIM));
  p_rd_pos_shrink_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (rd_q > 0)) |=> (rd_q <= $past(rd_q)));
  p_rd_neg_shrink_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (rd_q < 0)) |=> (rd_q >= $past(rd_q)));
endmodule

// File: rtl/pfs_frame_shifter.sv
module pfs_frame_shifter #(
  parameter int unsigned FRAME_LEN = 28
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_en,
  input  logic [FRAME_LEN-1:0] frame_in,
  output logic                 frame_load,
  output logic                 ser_bit,
  output logic                 frame_start
);
  localparam int unsigned SW = $clog2(FRAME_LEN);

  logic [SW-1:0]        slot_q, slot_d;
  logic [FRAME_LEN-1:0] frame_q, frame_d;
  logic                 ser_q, ser_d;
  logic                 start_q, start_d;

  assign frame_load = bit_en && (slot_q == '0);

  always_comb begin
    slot_d  = slot_q;
    frame_d = frame_q;
    ser_d   = ser_q;
    start_d = start_q;
    if (bit_en) begin
      slot_d  = (slot_q == SW'(FRAME_LEN - 1)) ? '0 : slot_q + 1'b1;
      start_d = (slot_q == '0);
      if (slot_q == '0) begin
        frame_d = frame_in;
        ser_d   = frame_in[0];
      end else begin
        ser_d   = frame_q[slot_q];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      frame_q <= '0;
      ser_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      slot_q  <= slot_d;
      frame_q <= frame_d;
      ser_q   <= ser_d;
      start_q <= start_d;
    end
  end

  assign ser_bit     = ser_q;
  assign frame_start = start_q;

  p_slot_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q < SW'(FRAME_LEN));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(ser_q) && $stable(start_q)));
  p_marker_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> ser_q);
  p_marker_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && start_q) |=> (!ser_q && !start_q));
endmodule

// File: rtl/pixframe_ser.sv
module pixframe_ser
  import pfs_pkg::*;
#(
  parameter int unsigned DATA_W   = 24,
  parameter int unsigned CTRL_W   = 3,
  parameter int unsigned LFSR_W   = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'h801C,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter int unsigned RD_LIMIT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [DATA_W-1:0] pix_data,
  input  logic [CTRL_W-1:0] pix_ctrl,
  input  logic              pix_valid,
  output logic              ser_bit,
  output logic              frame_start
);
  localparam int unsigned FRAME_LEN = MARKER_SLOTS + DATA_W + EXTRA_SLOTS;
  localparam int unsigned PH_W      = (CTRL_W > 1) ? $clog2(CTRL_W) : 1;

  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  logic                 frame_load;
  logic [DATA_W-1:0]    mask, data_sel, scrambled, balanced;
  logic                 inverted;
  logic [PH_W-1:0]      phase_q, phase_d;
  logic                 ctrl_bit;
  logic [FRAME_LEN-1:0] frame_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pfs_scrambler #(
    .DATA_W (DATA_W),
    .LFSR_W (LFSR_W),
    .TAPS   (LFSR_TAPS),
    .SEED   (LFSR_SEED)
  ) scr_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .advance (frame_load),
    .mask    (mask)
  );

  assign data_sel  = pix_valid ? pix_data : '0;
  assign scrambled = data_sel ^ mask;

  pfs_dc_balancer #(
    .DATA_W   (DATA_W),
    .RD_LIMIT (RD_LIMIT)
  ) bal_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .commit   (frame_load),
    .word_in  (scrambled),
    .word_out (balanced),
    .inverted (inverted)
  );

  always_comb begin
    ctrl_bit = 1'b0;
    for (int i = 0; i < CTRL_W; i++) begin
      if (phase_q == PH_W'(i)) ctrl_bit = pix_ctrl[i];
    end
    phase_d = phase_q;
    if (frame_load) begin
      phase_d = (phase_q == PH_W'(CTRL_W - 1)) ? '0 : phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) phase_q <= '0;
    else            phase_q <= phase_d;
  end

  assign frame_word = {ctrl_bit, inverted, balanced, MARK_LO, MARK_HI};

  pfs_frame_shifter #(
    .FRAME_LEN (FRAME_LEN)
  ) shf_i (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .bit_en      (bit_en),
    .frame_in    (frame_word),
    .frame_load  (frame_load),
    .ser_bit     (ser_bit),
    .frame_start (frame_start)
  );

  p_phase_range_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    phase_q < PH_W'(CTRL_W));
  p_phase_hold_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !frame_load |=> $stable(phase_q));
  p_reset_quiet_r11: assert property (@(posedge clk)
    !rst_int_n |-> (!ser_bit && !frame_start));
endmodule

// File: tb/pixframe_ser_tb.sv
module pixframe_ser_tb_top;
  logic        clk;
  logic        rst_n;
  logic        bit_en;
  logic [23:0] pix_data;
  logic [2:0]  pix_ctrl;
  logic        pix_valid;
  logic        ser_bit;
  logic        frame_start;

  int n_cmp;
  int n_bad;
  bit finished;

  logic [15:0] m_lfsr;
  int          m_rd;
  int          m_phase;

  pixframe_ser dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .pix_data    (pix_data),
    .pix_ctrl    (pix_ctrl),
    .pix_valid   (pix_valid),
    .ser_bit     (ser_bit),
    .frame_start (frame_start)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_lfsr  = 16'hACE1;
    m_rd    = 0;
    m_phase = 0;
  endtask

  task automatic model_frame(input logic [23:0] d, input logic [2:0] c,
                             input logic v, output logic [27:0] exp);
    logic [23:0] mask, scr, tx;
    int          ones, wd, sd;
    logic        inv, cb, fb;
    mask = {m_lfsr[7:0], m_lfsr};
    scr  = (v ? d : 24'h0) ^ mask;
    ones = $countones(scr);
    wd   = 2 * ones - 24;
    inv  = ((m_rd > 0) && (wd > 0)) || ((m_rd < 0) && (wd < 0));
    tx   = inv ? ~scr : scr;
    sd   = inv ? -wd : wd;
    m_rd = m_rd + sd;
    if (m_rd > 64)  m_rd = 64;
    if (m_rd < -64) m_rd = -64;
    cb      = c[m_phase];
    m_phase = (m_phase + 1) % 3;
    fb      = m_lfsr[15] ^ m_lfsr[4] ^ m_lfsr[3] ^ m_lfsr[2];
    m_lfsr  = {m_lfsr[14:0], fb};
    exp     = {cb, inv, tx, 1'b0, 1'b1};
  endtask

  task automatic run_frame(input logic [23:0] d, input logic [2:0] c, input logic v,
                           input int gap, input bit mid, input string preq,
                           output logic [27:0] got);
    logic [27:0] exp, fs;
    bit          hold_ok;
    hold_ok = 1'b1;
    model_frame(d, c, v, exp);
    pix_data  = d;
    pix_ctrl  = c;
    pix_valid = v;
    for (int s = 0; s < 28; s++) begin
      bit_en = 1'b1;
      @(negedge clk);
      got[s] = ser_bit;
      fs[s]  = frame_start;
      bit_en = 1'b0;
      if (mid && s == 0) begin
        pix_data  = ~d;
        pix_ctrl  = ~c;
        pix_valid = ~v;
      end
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        if (ser_bit !== got[s] || frame_start !== fs[s]) hold_ok = 1'b0;
      end
    end
    check(got[1:0] == 2'b01, "R2 markers", {30'h0, got[1:0]}, 32'h1);
    check(fs == 28'h1, "R1 start strobe", {4'h0, fs}, 32'h1);
    check(got[25:2] == exp[25:2], preq, {8'h0, got[25:2]}, {8'h0, exp[25:2]});
    check(got[26] == exp[26], "R5 inversion flag", {31'h0, got[26]}, {31'h0, exp[26]});
    check(got[27] == exp[27], "R7 control slot", {31'h0, got[27]}, {31'h0, exp[27]});
    if (gap > 0) check(hold_ok, "R10 hold without enable", {31'h0, hold_ok}, 32'h1);
  endtask

  task automatic do_reset();
    bit_en = 1'b0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    check(ser_bit == 1'b0 && frame_start == 1'b0, "R11 reset outputs",
          {30'h0, ser_bit, frame_start}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(ser_bit == 1'b0 && frame_start == 1'b0, "R11 idle after release",
          {30'h0, ser_bit, frame_start}, 32'h0);
    model_reset();
  endtask

  task automatic t_first_frame();
    logic [27:0] got;
    run_frame(24'h0, 3'b000, 1'b1, 0, 1'b0, "R3 payload", got);
    check(got[25:2] == 24'hE1ACE1, "R4 seed mask", {8'h0, got[25:2]}, 32'hE1ACE1);
    check(got[26] == 1'b0, "R6 zero start disparity", {31'h0, got[26]}, 32'h0);
  endtask

  task automatic t_patterns();
    logic [27:0] got;
    run_frame(24'hFFFFFF, 3'b001, 1'b1, 0, 1'b0, "R3 all ones", got);
    run_frame(24'h555555, 3'b010, 1'b1, 0, 1'b0, "R3 alternating", got);
    run_frame(24'h123456, 3'b100, 1'b1, 0, 1'b0, "R3 ramp", got);
    run_frame(24'hF0F0F0, 3'b111, 1'b1, 0, 1'b0, "R3 nibbles", got);
    run_frame(24'h000FFF, 3'b101, 1'b1, 0, 1'b0, "R3 half", got);
    run_frame(24'hA5A5A5, 3'b010, 1'b1, 0, 1'b0, "R3 mixed", got);
    for (int k = 0; k < 6; k++) begin
      run_frame(24'h0F0F0F + 24'(k * 24'h111111), 3'(k), 1'b1, 0, 1'b0,
                "R5 disparity run", got);
    end
  endtask

  task automatic t_gaps();
    logic [27:0] got;
    run_frame(24'hC3C3C3, 3'b011, 1'b1, 2, 1'b0, "R10 gapped payload", got);
    run_frame(24'h3C3C3C, 3'b110, 1'b1, 1, 1'b0, "R10 gapped payload", got);
  endtask

  task automatic t_invalid();
    logic [27:0] got;
    run_frame(24'hABCDEF, 3'b111, 1'b0, 0, 1'b0, "R9 invalid zeroes data", got);
  endtask

  task automatic t_midchange();
    logic [27:0] got;
    run_frame(24'h89ABCD, 3'b010, 1'b1, 0, 1'b1, "R8 mid-frame change ignored", got);
    run_frame(24'h13579B, 3'b101, 1'b1, 0, 1'b0, "R8 next frame samples", got);
  endtask

  task automatic t_rereset();
    logic [27:0] got;
    pix_data  = 24'h777777;
    pix_valid = 1'b1;
    for (int s = 0; s < 10; s++) begin
      bit_en = 1'b1;
      @(negedge clk);
    end
    do_reset();
    run_frame(24'h0, 3'b001, 1'b1, 0, 1'b0, "R11 fresh payload", got);
    check(got[25:2] == 24'hE1ACE1, "R4 seed after reset", {8'h0, got[25:2]}, 32'hE1ACE1);
    check(got[27] == 1'b1, "R7 index zero after reset", {31'h0, got[27]}, 32'h1);
    check(got[26] == 1'b0, "R6 disparity cleared", {31'h0, got[26]}, 32'h0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    n_cmp     = 0;
    n_bad     = 0;
    finished  = 1'b0;
    bit_en    = 1'b0;
    pix_data  = '0;
    pix_ctrl  = '0;
    pix_valid = 1'b0;
    rst_n     = 1'b0;
    model_reset();
    do_reset();
    t_first_frame();
    t_patterns();
    t_gaps();
    t_invalid();
    t_midchange();
    t_rereset();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule